// File: doc/BRIEF.md
# Parallel Direct-Injection CRC Engine

This block computes a cyclic redundancy check over a message that arrives several bits per clock. Each accepted data word is XOR-ed into the most significant end of the running remainder. The sum is then multiplied over GF(2) by the state-transition matrix raised to the word width. Because the data enters ahead of the matrix, the register holds the finished check value one clock after the last message word. No block of trailing zero bits has to be pushed through.

The generator polynomial, the remainder width and the word width are parameters. The transition matrix is derived from the polynomial while the design is elaborated. A transmitter reads the check value from `fcs_o` and appends it to the frame. A receiver runs the message followed by the appended check value through the same engine and reads `ok_o`, which is high when the remainder has returned to zero.

Top module: `pcrc_direct`

## Requirements
- R1: An active-low asynchronous reset clears the remainder to all zeros and drives `ok_o` low at once, with no clock edge needed.
- R2: On each clock with `valid_i` high, the remainder becomes F^W ⊗ (X ⊕ D). Here F is the one-bit shift matrix of polynomial `POLY`, whose bit i is the coefficient of x^i with the x^CRC_W term implied. D has `data_i` in bits CRC_W-1 down to CRC_W-DATA_W and zeros below. `data_i[DATA_W-1]` is the earliest message bit.
- R3: After the last word of a message, with no zero words sent, `fcs_o` equals the remainder of M(x)·x^CRC_W divided by the generator. M(x) is the message taken most significant bit first, starting from a zero remainder.
- R4: While `valid_i` and `start_i` are both low, `fcs_o` and `ok_o` hold their values.
- R5: `start_i` clears the remainder synchronously. If `valid_i` is high in the same cycle, that word is processed against a zero remainder as the first word of a new frame, so frames can run back to back.
- R6: `ok_o` is high exactly when at least one word has been accepted since the last start or reset and the remainder is zero. A frame followed by its own check value, most significant byte first, therefore gives `ok_o` high.
- R7: A frame whose appended check value has any single bit inverted leaves `ok_o` low.
- R8: With CRC_W=16 and POLY=16'h8005, word widths 8 and 16 yield the same check value for the same byte sequence. The 16-bit word carries the earlier byte in its upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| start_i | input | 1 | Synchronous frame restart |
| valid_i | input | 1 | Qualifies `data_i` for this cycle |
| data_i | input | DATA_W | Message word, earliest bit in the MSB |
| fcs_o | output | CRC_W | Running remainder / check value |
| ok_o | output | 1 | Remainder is zero after at least one word |

## Verification
The bench sweeps every single-byte message and walks a lone one bit through every position of a 16-bit word. These sweeps catch a wrong matrix column, a swapped bit order, or data injected at the low end instead of the high end, because each of those faults produces a check value that differs from the bench's serial long division. It runs random multi-byte frames through the 8-bit and 16-bit configurations side by side, so a word-width-dependent matrix error shows up as a disagreement between them. Idle gaps in the middle of a frame catch an engine that advances without `valid_i`. A start pulse that arrives together with data catches an engine that merges the old remainder into the new frame. A start pulse with no data catches an `ok_o` that rises on an empty frame. Inverting one bit of the appended check value catches a receiver check that ignores low-order bits.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;

    localparam int unsigned PCRC_MAX_W = 64;

    // Multiply a remainder by x modulo the generator (one serial step, zero input).
    function automatic logic [PCRC_MAX_W-1:0] gf2_mulx(
        input logic [PCRC_MAX_W-1:0] v,
        input logic [PCRC_MAX_W-1:0] poly,
        input int unsigned           width
    );
        logic [PCRC_MAX_W-1:0] mask;
        logic [PCRC_MAX_W-1:0] r;
        logic                  top;
        mask = '0;
        for (int unsigned b = 0; b < PCRC_MAX_W; b++) begin
            if (b < width) mask[b] = 1'b1;
        end
        top = v[width-1];
        r   = (v << 1) & mask;
        if (top) r = r ^ (poly & mask);
        return r;
    endfunction

endpackage

// File: rtl/pcrc_inject.sv
module pcrc_inject #(
    parameter int unsigned CRC_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic [CRC_W-1:0]  state_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  vec_o
);
    localparam int unsigned PAD_W = CRC_W - DATA_W;

    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] aligned;

    always_comb begin
        base = clear_i ? '0 : state_i;
    end

    generate
        if (PAD_W == 0) begin : g_full
            assign aligned = data_i;
        end else begin : g_pad
            assign aligned = {data_i, {PAD_W{1'b0}}};
        end
    endgenerate

    assign vec_o = base ^ aligned;

endmodule

// File: rtl/pcrc_matrix.sv
module pcrc_matrix #(
    parameter int unsigned       CRC_W  = 16,
    parameter int unsigned       DATA_W = 8,
    parameter logic [CRC_W-1:0]  POLY   = 16'h8005
) (
    input  logic [CRC_W-1:0] vec_i,
    output logic [CRC_W-1:0] vec_o
);
    import pcrc_pkg::*;

    localparam int unsigned CELLS = CRC_W * CRC_W;

    // Row-major flat matrix: bit (i*CRC_W + j) is entry (row i, column j) of F^DATA_W.
    function automatic logic [CELLS-1:0] build_rows();
        logic [CELLS-1:0]      acc;
        logic [PCRC_MAX_W-1:0] v;
        acc = '0;
        for (int unsigned j = 0; j < CRC_W; j++) begin
            v    = '0;
            v[j] = 1'b1;
            for (int unsigned s = 0; s < DATA_W; s++) begin
                v = gf2_mulx(v, PCRC_MAX_W'(POLY), CRC_W);
            end
            for (int unsigned i = 0; i < CRC_W; i++) begin
                acc[i*CRC_W + j] = v[i];
            end
        end
        return acc;
    endfunction

    localparam logic [CELLS-1:0] ROWS = build_rows();

    generate
        for (genvar i = 0; i < CRC_W; i++) begin : g_row
            assign vec_o[i] = ^(ROWS[i*CRC_W +: CRC_W] & vec_i);
        end
    endgenerate

    // A linear map sends zero to zero (R2).
    always_comb begin
        if (vec_i == '0) begin
            assert_linear_zero_R2: assert (vec_o == '0);
        end
    end

endmodule

// File: rtl/pcrc_zero.sv
module pcrc_zero #(
    parameter int unsigned CRC_W = 16
) (
    input  logic [CRC_W-1:0] state_i,
    output logic             zero_o
);
    assign zero_o = (state_i == '0);
endmodule

// File: rtl/pcrc_direct.sv
module pcrc_direct #(
    parameter int unsigned      CRC_W  = 16,
    parameter int unsigned      DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h8005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  fcs_o,
    output logic              ok_o
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             seen;
    } pcrc_state_t;

    pcrc_state_t st_d, st_q;

    logic [CRC_W-1:0] mixed;
    logic [CRC_W-1:0] advanced;
    logic             is_zero;

    pcrc_inject #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_inject (
        .state_i (st_q.crc),
        .clear_i (start_i),
        .data_i  (data_i),
        .vec_o   (mixed)
    );

    pcrc_matrix #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_matrix (
        .vec_i (mixed),
        .vec_o (advanced)
    );

    pcrc_zero #(.CRC_W(CRC_W)) u_zero (
        .state_i (st_q.crc),
        .zero_o  (is_zero)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.crc  = '0;
            st_d.seen = 1'b0;
        end
        if (valid_i) begin
            st_d.crc  = advanced;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fcs_o = st_q.crc;
    assign ok_o  = st_q.seen & is_zero;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> ($stable(fcs_o) && $stable(ok_o)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) |=> (fcs_o == '0 && !ok_o));

    assert_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && data_i == '0 && fcs_o == '0) |=> (fcs_o == '0));

    assert_ok_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(valid_i));

endmodule

// File: tb/tb_pcrc_direct.sv
module tb_pcrc_direct;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] GEN = 16'h8005;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        start8 = 0, valid8 = 0;
    logic [7:0]  data8 = '0;
    logic [15:0] fcs8;
    logic        ok8;

    logic        start16 = 0, valid16 = 0;
    logic [15:0] data16 = '0;
    logic [15:0] fcs16;
    logic        ok16;

    int total = 0;
    int bad = 0;
    logic [7:0] msg [0:63];
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcrc_direct #(.CRC_W(16), .DATA_W(8), .POLY(GEN)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start8), .valid_i(valid8),
        .data_i(data8), .fcs_o(fcs8), .ok_o(ok8));

    pcrc_direct #(.CRC_W(16), .DATA_W(16), .POLY(GEN)) dut16 (
        .clk(clk), .rst_n(rst_n), .start_i(start16), .valid_i(valid16),
        .data_i(data16), .fcs_o(fcs16), .ok_o(ok16));

    task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [31:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Serial long division of message * x^16 (message then 16 zero bits).
    function automatic logic [15:0] ref_fcs(input int nbytes);
        logic [15:0] r;
        logic        fb;
        r = '0;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 7; b >= 0; b--) begin
                fb = r[15];
                r  = {r[14:0], msg[i][b]};
                if (fb) r = r ^ GEN;
            end
        end
        for (int z = 0; z < 16; z++) begin
            fb = r[15];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ GEN;
        end
        return r;
    endfunction

    task automatic put8(input logic st, input logic [7:0] b);
        @(negedge clk);
        start8 = st; valid8 = 1'b1; data8 = b;
    endtask

    task automatic idle8();
        @(negedge clk);
        start8 = 1'b0; valid8 = 1'b0; data8 = '0;
    endtask

    task automatic put16(input logic st, input logic [15:0] w);
        @(negedge clk);
        start16 = st; valid16 = 1'b1; data16 = w;
    endtask

    task automatic idle16();
        @(negedge clk);
        start16 = 1'b0; valid16 = 1'b0; data16 = '0;
    endtask

    // Send msg[0..n-1] on the 8-bit engine, check check value, then append it and check ok.
    task automatic frame8(input int n, input bit flip, output logic [15:0] got);
        logic [15:0] exp;
        exp = ref_fcs(n);
        for (int i = 0; i < n; i++) put8(i == 0, msg[i]);
        idle8();
        got = fcs8;
        chk(fcs8 == exp, "R3 fcs8", {16'h0, fcs8}, {16'h0, exp});
        chk(ok8 == (exp == 16'h0), "R6 ok8 before append", {31'h0, ok8}, {31'h0, exp == 16'h0});
        put8(1'b0, exp[15:8]);
        put8(1'b0, exp[7:0] ^ {7'h0, flip});
        idle8();
        if (flip)
            chk(ok8 == 1'b0, "R7 corrupted append", {31'h0, ok8}, 32'h0);
        else
            chk(ok8 == 1'b1, "R6 receiver ok8", {31'h0, ok8}, 32'h1);
    endtask

    task automatic frame16(input int nwords, output logic [15:0] got);
        logic [15:0] exp;
        exp = ref_fcs(2 * nwords);
        for (int i = 0; i < nwords; i++) put16(i == 0, {msg[2*i], msg[2*i+1]});
        idle16();
        got = fcs16;
        chk(fcs16 == exp, "R2 fcs16", {16'h0, fcs16}, {16'h0, exp});
        put16(1'b0, exp);
        idle16();
        chk(ok16 == 1'b1, "R6 receiver ok16", {31'h0, ok16}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] g8, g16, hold;
        int nb;
        #1;
        chk(fcs8 == 16'h0 && !ok8, "R1 reset state w8", {15'h0, ok8, fcs8}, 32'h0);
        chk(fcs16 == 16'h0 && !ok16, "R1 reset state w16", {15'h0, ok16, fcs16}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Known value: single byte 0x01 -> 0x8005 * ... computed by reference
        // R3: exhaustive single-byte messages, back-to-back frames via start with data (R5)
        for (int b = 0; b < 256; b++) begin
            msg[0] = b[7:0];
            frame8(1, 1'b0, g8);
            if (b % 16 == 5) frame8(1, 1'b1, g8);
        end

        // R2: walking one through a 16-bit word
        for (int k = 0; k < 16; k++) begin
            logic [15:0] w;
            w = 16'h1 << k;
            msg[0] = w[15:8];
            msg[1] = w[7:0];
            frame16(1, g16);
        end

        // R8: random multi-byte frames on both widths agree
        for (int f = 0; f < 40; f++) begin
            nb = 2 * (1 + int'(next_rand() % 8));
            for (int i = 0; i < nb; i++) msg[i] = next_rand() & 8'hff;
            frame8(nb, 1'b0, g8);
            frame16(nb / 2, g16);
            chk(g8 == g16, "R8 width equivalence", {16'h0, g8}, {16'h0, g16});
        end

        // R4: idle gaps inside a frame do not disturb the remainder
        for (int i = 0; i < 6; i++) msg[i] = next_rand() & 8'hff;
        for (int i = 0; i < 6; i++) begin
            put8(i == 0, msg[i]);
            idle8();
            hold = fcs8;
            @(negedge clk);
            @(negedge clk);
            chk(fcs8 == hold, "R4 hold while idle", {16'h0, fcs8}, {16'h0, hold});
        end
        chk(fcs8 == ref_fcs(6), "R4 gapped frame result", {16'h0, fcs8}, {16'h0, ref_fcs(6)});

        // R5/R6: start with no data clears and leaves ok low
        @(negedge clk);
        start8 = 1'b1; valid8 = 1'b0;
        idle8();
        chk(fcs8 == 16'h0, "R5 start clears", {16'h0, fcs8}, 32'h0);
        chk(ok8 == 1'b0, "R6 no word seen", {31'h0, ok8}, 32'h0);

        // R1: asynchronous clear mid-frame
        put8(1'b1, 8'hA5);
        put8(1'b0, 8'h3C);
        idle8();
        chk(fcs8 != 16'h0, "R1 precondition nonzero", {16'h0, fcs8}, 32'h1);
        #2;
        rst_n = 1'b0;
        #1;
        chk(fcs8 == 16'h0 && !ok8, "R1 async clear", {15'h0, ok8, fcs8}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        report();
    end

endmodule